// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger

This block holds the transmit and receive byte FIFOs for one UART channel. It also holds the control register that configures them. The host programs the block through a write-only control byte. That byte turns both FIFOs on or off, clears either FIFO, selects the DMA signalling mode and picks the receive interrupt threshold. The receive shifter pushes bytes into the receive FIFO and the host pops them. The host pushes into the transmit FIFO and the transmit shifter pops from it.

The block raises a receive-data interrupt request while the receive FIFO holds at least the selected number of bytes. The top two bits of the interrupt status byte show whether the FIFOs are on.

When the FIFOs are off, each direction behaves as a single-byte holding register and the interrupt threshold is one byte. Pushing into a FIFO that has no room loses the byte and sets a sticky overrun flag. Popping an empty FIFO changes nothing.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After the synchronous reset, all of the following hold: the FIFOs are off, DMA mode is 0, the trigger code is 00, both counts are 0, both empty flags are 1, both overrun flags are 0, `rx_irq` is 0 and `isr_fifo_en` is 00.
- R2: Bit 0 of every control write is stored. Bits 1, 2, 3 and 7:6 act only when bit 0 of the same write is 1. Bits 5:4 are ignored. New settings show on the outputs from the cycle after the write.
- R3: A control write with bits 1 and 0 set empties the receive FIFO and clears its overrun flag at that edge. The transmit FIFO is untouched, and later writes do not repeat the clear.
- R4: A control write with bits 2 and 0 set empties the transmit FIFO and clears its overrun flag in the same way. The receive FIFO is untouched.
- R5: `dma_mode` follows bit 3 of the last control write that had bit 0 set.
- R6: While the FIFOs are on, trigger code bits 7:6 select the threshold: 00 is 1, 01 is 4, 10 is 8 and 11 is 14 bytes. `rx_irq` is 1 exactly while `rx_count` is at or above the threshold, so it falls as soon as the count drops below it.
- R7: `isr_fifo_en` reads 11 while the FIFOs are on and 00 while they are off.
- R8: While the FIFOs are off, each FIFO holds at most one byte and the receive threshold is 1.
- R9: A control write whose bit 0 differs from the stored enable empties both FIFOs and clears both overrun flags.
- R10: Each FIFO returns bytes in arrival order. Its count runs from 0 to 16, with empty when the count is 0 and full when the count reaches capacity. An accepted pop loads the oldest byte into the pop-data output at that edge.
- R11: A push while a FIFO is full is dropped and sets the sticky overrun flag. A push and a pop in the same cycle on a full FIFO accept the pop and drop the push.
- R12: A pop from an empty FIFO leaves the pop data, the count and the flags unchanged.
- R13: A clear at the same edge as a push drops the push without setting overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| rxf_push | input | 1 | Receive shifter pushes a byte |
| rxf_push_data | input | 8 | Received byte |
| rxf_pop | input | 1 | Host pops a received byte |
| rxf_pop_data | output | 8 | Last byte popped from the receive FIFO |
| rxf_count | output | 5 | Receive FIFO occupancy |
| rxf_empty | output | 1 | Receive FIFO empty |
| rxf_full | output | 1 | Receive FIFO at capacity |
| rxf_overrun | output | 1 | Sticky receive overrun |
| txf_push | input | 1 | Host pushes a byte to transmit |
| txf_push_data | input | 8 | Byte to transmit |
| txf_pop | input | 1 | Transmit shifter pops a byte |
| txf_pop_data | output | 8 | Last byte popped from the transmit FIFO |
| txf_count | output | 5 | Transmit FIFO occupancy |
| txf_empty | output | 1 | Transmit FIFO empty |
| txf_full | output | 1 | Transmit FIFO at capacity |
| txf_overrun | output | 1 | Sticky transmit overrun |
| rx_irq | output | 1 | Receive-data interrupt request |
| dma_mode | output | 1 | DMA signalling mode selected |
| isr_fifo_en | output | 2 | FIFO-enabled bits of the status byte |

## Verification
Counts, flags, overrun and pop data change at the clock edge that takes the push, pop or clear, so they are due one cycle after the stimulus. The status bits, DMA mode and the threshold are also due one cycle after a control write. `rx_irq` is combinational from the registered count and settings, so it changes in the same cycle as the count. The bench drives every input on the falling edge and compares all outputs with its queue-based model at the next falling edge, which is exactly one rising edge later.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic      enable;
        logic      dma;
        trig_sel_e trig;
    } ufc_cfg_t;

    typedef struct packed {
        logic rx_clr;
        logic tx_clr;
    } ufc_clr_t;

    localparam int unsigned CTL_EN_BIT    = 0;
    localparam int unsigned CTL_RXCLR_BIT = 1;
    localparam int unsigned CTL_TXCLR_BIT = 2;
    localparam int unsigned CTL_DMA_BIT   = 3;
    localparam int unsigned CTL_TRIG_LSB  = 6;

    // Threshold in bytes for a trigger code, limited to the FIFO depth.
    function automatic int unsigned trig_bytes(trig_sel_e sel, int unsigned depth);
        int unsigned v;
        case (sel)
            TRIG_ONE:      v = 1;
            TRIG_FOUR:     v = 4;
            TRIG_EIGHT:    v = 8;
            default:       v = 14;
        endcase
        if (v > depth) v = depth;
        return v;
    endfunction

endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output ufc_cfg_t   cfg,
    output ufc_clr_t   clr
);
    logic en_bit;
    logic flush;
    logic unused_rsvd;

    assign en_bit      = wdata[CTL_EN_BIT];
    assign unused_rsvd = ^wdata[5:4];
    assign flush       = we && (en_bit != cfg.enable);

    always_comb begin
        clr.rx_clr = flush || (we && en_bit && wdata[CTL_RXCLR_BIT]);
        clr.tx_clr = flush || (we && en_bit && wdata[CTL_TXCLR_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{enable: 1'b0, dma: 1'b0, trig: TRIG_ONE};
        end else if (we) begin
            cfg.enable <= en_bit;
            if (en_bit) begin
                cfg.dma  <= wdata[CTL_DMA_BIT];
                cfg.trig <= trig_sel_e'(wdata[CTL_TRIG_LSB +: 2]);
            end
        end
    end
endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          single,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          overrun
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] step_ptr(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign cap     = single ? CW'(1) : CW'(DEPTH);
    assign empty   = (count == '0);
    assign full    = (count >= cap);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_ff @(posedge clk) begin
        if (!rst && !clr && push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overrun  <= 1'b0;
            pop_data <= '0;
        end else if (clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= step_ptr(wr_ptr);
            if (push && full) overrun <= 1'b1;
            if (pop_ok) begin
                pop_data <= mem[rd_ptr];
                rd_ptr   <= step_ptr(rd_ptr);
            end
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/ufc_rx_trigger.sv
module ufc_rx_trigger
    import ufc_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  ufc_cfg_t      cfg,
    input  logic [CW-1:0] count,
    output logic          irq
);
    logic [CW-1:0] level;

    assign level = cfg.enable ? CW'(trig_bytes(cfg.trig, DEPTH)) : CW'(1);
    assign irq   = (count >= level);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import ufc_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_wdata,
    input  logic          rxf_push,
    input  logic [DW-1:0] rxf_push_data,
    input  logic          rxf_pop,
    output logic [DW-1:0] rxf_pop_data,
    output logic [CW-1:0] rxf_count,
    output logic          rxf_empty,
    output logic          rxf_full,
    output logic          rxf_overrun,
    input  logic          txf_push,
    input  logic [DW-1:0] txf_push_data,
    input  logic          txf_pop,
    output logic [DW-1:0] txf_pop_data,
    output logic [CW-1:0] txf_count,
    output logic          txf_empty,
    output logic          txf_full,
    output logic          txf_overrun,
    output logic          rx_irq,
    output logic          dma_mode,
    output logic [1:0]    isr_fifo_en
);
    localparam int NDIR = 2;   // index 0 receive, 1 transmit

    ufc_cfg_t      cfg;
    ufc_clr_t      clr;
    logic          d_clr   [NDIR];
    logic          d_push  [NDIR];
    logic          d_pop   [NDIR];
    logic [DW-1:0] d_wdata [NDIR];
    logic [DW-1:0] d_rdata [NDIR];
    logic [CW-1:0] d_count [NDIR];
    logic          d_empty [NDIR];
    logic          d_full  [NDIR];
    logic          d_ovr   [NDIR];

    ufc_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .cfg   (cfg),
        .clr   (clr)
    );

    assign d_clr[0]   = clr.rx_clr;
    assign d_clr[1]   = clr.tx_clr;
    assign d_push[0]  = rxf_push;
    assign d_push[1]  = txf_push;
    assign d_pop[0]   = rxf_pop;
    assign d_pop[1]   = txf_pop;
    assign d_wdata[0] = rxf_push_data;
    assign d_wdata[1] = txf_push_data;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ufc_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .clr       (d_clr[d]),
            .single    (!cfg.enable),
            .push      (d_push[d]),
            .push_data (d_wdata[d]),
            .pop       (d_pop[d]),
            .pop_data  (d_rdata[d]),
            .count     (d_count[d]),
            .empty     (d_empty[d]),
            .full      (d_full[d]),
            .overrun   (d_ovr[d])
        );
    end

    ufc_rx_trigger #(.DEPTH(DEPTH)) u_trig (
        .cfg   (cfg),
        .count (d_count[0]),
        .irq   (rx_irq)
    );

    assign rxf_pop_data = d_rdata[0];
    assign rxf_count    = d_count[0];
    assign rxf_empty    = d_empty[0];
    assign rxf_full     = d_full[0];
    assign rxf_overrun  = d_ovr[0];
    assign txf_pop_data = d_rdata[1];
    assign txf_count    = d_count[1];
    assign txf_empty    = d_empty[1];
    assign txf_full     = d_full[1];
    assign txf_overrun  = d_ovr[1];
    assign dma_mode     = cfg.dma;
    assign isr_fifo_en  = {2{cfg.enable}};
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          ctl_we,
    input logic [7:0]    ctl_wdata,
    input logic          rxf_push,
    input logic          rxf_pop,
    input logic [DW-1:0] rxf_pop_data,
    input logic [CW-1:0] rxf_count,
    input logic          rxf_empty,
    input logic          rxf_full,
    input logic          rxf_overrun,
    input logic [CW-1:0] txf_count,
    input logic          rx_irq,
    input logic          dma_mode,
    input logic [1:0]    isr_fifo_en
);
    AST_ENABLE_SHOWS: assert property (@(posedge clk) disable iff (rst)
        ctl_we && ctl_wdata[0] |=> isr_fifo_en == 2'b11);                       // R7
    AST_DMA_HELD: assert property (@(posedge clk) disable iff (rst)
        ctl_we && !ctl_wdata[0] |=> $stable(dma_mode));                         // R2
    AST_RX_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ctl_we && ctl_wdata[0] && ctl_wdata[1] |=> rxf_count == '0 && !rxf_overrun); // R3
    AST_TX_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ctl_we && ctl_wdata[0] && ctl_wdata[2] |=> txf_count == '0);            // R4
    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (rst)
        isr_fifo_en == 2'b00 |-> rxf_count <= CW'(1) && txf_count <= CW'(1));   // R8
    AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
        isr_fifo_en == 2'b00 |-> rx_irq == !rxf_empty);                        // R8
    AST_IRQ_FULL: assert property (@(posedge clk) disable iff (rst)
        rxf_full && isr_fifo_en == 2'b11 |-> rx_irq);                          // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        rxf_full && rxf_push && !rxf_pop && !ctl_we |=> rxf_overrun && $stable(rxf_count)); // R11
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        rxf_empty && rxf_pop && !rxf_push && !ctl_we |=> $stable(rxf_pop_data) && rxf_empty); // R12
endmodule

bind uart_fifo_ctl ufc_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl_we       (ctl_we),
    .ctl_wdata    (ctl_wdata),
    .rxf_push     (rxf_push),
    .rxf_pop      (rxf_pop),
    .rxf_pop_data (rxf_pop_data),
    .rxf_count    (rxf_count),
    .rxf_empty    (rxf_empty),
    .rxf_full     (rxf_full),
    .rxf_overrun  (rxf_overrun),
    .txf_count    (txf_count),
    .rx_irq       (rx_irq),
    .dma_mode     (dma_mode),
    .isr_fifo_en  (isr_fifo_en)
);

// File: tb/sim_uart_fifo_ctl.sv
`timescale 1ns/1ps
module sim_uart_fifo_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       rxf_push = 1'b0, rxf_pop = 1'b0, txf_push = 1'b0, txf_pop = 1'b0;
    logic [7:0] rxf_push_data = '0, txf_push_data = '0;
    logic [7:0] rxf_pop_data, txf_pop_data;
    logic [4:0] rxf_count, txf_count;
    logic       rxf_empty, rxf_full, rxf_overrun, txf_empty, txf_full, txf_overrun;
    logic       rx_irq, dma_mode;
    logic [1:0] isr_fifo_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [7:0] rq[$];
    logic [7:0] tq[$];
    bit         m_en = 0, m_dma = 0, r_ovr = 0, t_ovr = 0;
    logic [1:0] m_trig = 2'b00;
    logic [7:0] r_pd = '0, t_pd = '0;

    always #2.5 clk = ~clk;

    uart_fifo_ctl u0 (.*);

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lvl(logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic mstep(ref logic [7:0] q[$], ref bit ovr, ref logic [7:0] pd,
                         input bit clr, input bit push, input bit pop,
                         input logic [7:0] d, input int cap);
        int pre;
        pre = q.size();
        if (clr) begin
            q.delete();
            ovr = 0;
        end else begin
            if (pop && pre > 0) pd = q.pop_front();
            if (push) begin
                if (pre < cap) q.push_back(d);
                else ovr = 1;
            end
        end
    endtask

    task automatic compare_all();
        int thr;
        thr = m_en ? lvl(m_trig) : 1;
        check("R10 rx count", rxf_count, rq.size());
        check("R10 rx empty", rxf_empty, rq.size() == 0);
        check("R10 rx full", rxf_full, rq.size() >= (m_en ? 16 : 1));
        check("R10 rx data", rxf_pop_data, r_pd);
        check("R11 rx overrun", rxf_overrun, r_ovr);
        check("R10 tx count", txf_count, tq.size());
        check("R10 tx empty", txf_empty, tq.size() == 0);
        check("R10 tx full", txf_full, tq.size() >= (m_en ? 16 : 1));
        check("R10 tx data", txf_pop_data, t_pd);
        check("R11 tx overrun", txf_overrun, t_ovr);
        check("R6 irq", rx_irq, rq.size() >= thr);
        check("R7 isr", isr_fifo_en, m_en ? 3 : 0);
        check("R5 dma", dma_mode, m_dma);
    endtask

    // one clock: drive at falling edge, model the rising edge, compare at next falling edge
    task automatic cyc(bit we = 0, logic [7:0] wd = 0, bit rp = 0, logic [7:0] rd = 0,
                       bit ro = 0, bit tp = 0, logic [7:0] td = 0, bit to = 0);
        bit flush, rclr, tclr;
        int cap;
        ctl_we = we; ctl_wdata = wd;
        rxf_push = rp; rxf_push_data = rd; rxf_pop = ro;
        txf_push = tp; txf_push_data = td; txf_pop = to;
        flush = we && (wd[0] != m_en);
        rclr  = flush || (we && wd[0] && wd[1]);
        tclr  = flush || (we && wd[0] && wd[2]);
        cap   = m_en ? 16 : 1;
        mstep(rq, r_ovr, r_pd, rclr, rp, ro, rd, cap);
        mstep(tq, t_ovr, t_pd, tclr, tp, to, td, cap);
        if (we) begin
            m_en = wd[0];
            if (wd[0]) begin
                m_dma  = wd[3];
                m_trig = wd[7:6];
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
        ctl_we = 0; rxf_push = 0; rxf_pop = 0; txf_push = 0; txf_pop = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 rx count", rxf_count, 0);
        check("R1 rx empty", rxf_empty, 1);
        check("R1 tx empty", txf_empty, 1);
        check("R1 isr", isr_fifo_en, 0);
        check("R1 irq", rx_irq, 0);
        check("R1 dma", dma_mode, 0);
        check("R1 overrun", rxf_overrun, 0);

        // disabled: one-byte holding register
        cyc(.rp(1), .rd(8'hA1));
        check("R8 one byte held", rxf_count, 1);
        check("R8 irq at one", rx_irq, 1);
        cyc(.rp(1), .rd(8'hA2));
        check("R11 dropped", rxf_count, 1);
        check("R11 overrun", rxf_overrun, 1);
        cyc(.ro(1));
        check("R10 pop data", rxf_pop_data, 8'hA1);
        cyc(.rp(1), .rd(8'h5C));
        cyc(.we(1), .wd(8'h02));
        check("R2 clear ignored without enable", rxf_count, 1);
        cyc(.we(1), .wd(8'h08));
        check("R2 dma ignored without enable", dma_mode, 0);

        // enable flushes
        cyc(.we(1), .wd(8'h01));
        check("R9 flush on enable", rxf_count, 0);
        check("R9 overrun cleared", rxf_overrun, 0);
        check("R7 isr on", isr_fifo_en, 3);

        // fill, overflow, push+pop on full
        for (int i = 0; i < 16; i++) cyc(.rp(1), .rd(8'(8'h10 + i)));
        check("R10 full at 16", rxf_full, 1);
        check("R10 count 16", rxf_count, 16);
        cyc(.rp(1), .rd(8'hEE));
        check("R11 overrun on full", rxf_overrun, 1);
        cyc(.rp(1), .rd(8'h77), .ro(1));
        check("R11 pop wins on full", rxf_count, 15);
        check("R10 oldest first", rxf_pop_data, 8'h10);
        for (int i = 0; i < 15; i++) cyc(.ro(1));
        check("R10 last byte", rxf_pop_data, 8'h1F);
        cyc(.ro(1));
        check("R12 empty pop data", rxf_pop_data, 8'h1F);
        check("R12 empty pop count", rxf_count, 0);

        // trigger levels
        for (int s = 1; s < 4; s++) begin
            cyc(.we(1), .wd({2'(s), 6'b000011}));
            for (int i = 0; i < lvl(2'(s)) - 1; i++) cyc(.rp(1), .rd(8'(i)));
            check("R6 below threshold", rx_irq, 0);
            cyc(.rp(1), .rd(8'h3C));
            check("R6 at threshold", rx_irq, 1);
            cyc(.ro(1));
            check("R6 falls below", rx_irq, 0);
        end
        cyc(.we(1), .wd(8'h31));
        check("R2 reserved bits ignored", isr_fifo_en, 3);
        check("R2 trigger back to one", rx_irq, 1);

        // DMA
        cyc(.we(1), .wd(8'h09));
        check("R5 dma set", dma_mode, 1);
        cyc(.we(1), .wd(8'h01));
        check("R5 dma cleared", dma_mode, 0);

        // per-direction clears
        for (int i = 0; i < 3; i++) cyc(.tp(1), .td(8'(8'hB0 + i)));
        cyc(.we(1), .wd(8'h03));
        check("R3 rx cleared", rxf_count, 0);
        check("R3 tx untouched", txf_count, 3);
        cyc(.rp(1), .rd(8'h42));
        check("R3 clear self-clears", rxf_count, 1);
        cyc(.we(1), .wd(8'h05));
        check("R4 tx cleared", txf_count, 0);
        check("R4 rx untouched", rxf_count, 1);
        cyc(.we(1), .wd(8'h03), .rp(1), .rd(8'h99));
        check("R13 push dropped by clear", rxf_count, 0);
        check("R13 no overrun", rxf_overrun, 0);

        // disable flushes
        cyc(.rp(1), .rd(8'h01));
        cyc(.rp(1), .rd(8'h02));
        cyc(.we(1), .wd(8'hC0));
        check("R9 flush on disable", rxf_count, 0);
        check("R7 isr off", isr_fifo_en, 0);
        cyc(.we(1), .wd(8'h01));

        // mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            bit we;
            logic [7:0] wd;
            we = ($urandom_range(0, 40) == 0);
            wd = 8'($urandom);
            if ($urandom_range(0, 7) != 0) wd[0] = 1'b1;
            if ($urandom_range(0, 3) != 0) wd[2:1] = 2'b00;
            cyc(.we(we), .wd(wd),
                .rp($urandom_range(0, 1) == 1), .rd(8'($urandom)),
                .ro($urandom_range(0, 2) == 0),
                .tp($urandom_range(0, 2) == 0), .td(8'($urandom)),
                .to($urandom_range(0, 1) == 1));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule